// File: doc/BRIEF.md
# SPI Master with Mode-Fault Detection

This block is a byte-wide serial master that runs from a fast system clock. Firmware picks the clock polarity, the clock phase and a divider code. It then writes one byte. The block lowers its select output and toggles SCK sixteen times at the selected rate. On every bit it sends a data bit on MOSI and takes a bit from MISO, most significant bit first. When the last edge has passed, the select output goes high again. The received byte lands in a holding register and a completion flag is raised. If enabled, an interrupt line follows that flag.

The master also monitors a select input of its own. While it holds master mode, a falling edge on that input means another master has taken the bus. The block leaves master mode at once, stops the byte in flight and sets a sticky fault flag. A write made while a byte is being shifted is refused and marked with a collision flag. Dropping the enable input returns the serial engine and its flags to idle. The master-mode bit and the fault flag are kept.

Top module: `spi_mstr_core`

## Requirements
- R1: After reset, ss_n_out is 1, and busy, master_mode, done_flag, wcol_flag, fault_flag and irq are all 0.
- R2: An accepted write (wr_stb with en=1, master_mode=1, fault_flag=0 and busy=0) drives ss_n_out low. It exchanges eight bits MSB first: wr_data goes out on mosi, and the byte seen on miso ends up in rx_data. This holds in all four cpol/cpha combinations.
- R3: While no byte is in progress, sck rests at the level of cpol (0 means low, 1 means high). After the sixteenth edge it has returned to that level.
- R4: With cpha=0, mosi holds the MSB from the moment ss_n_out falls, and both lines are sampled on the first, third and every later odd edge. With cpha=1, data changes on the first edge of each bit and is sampled on the second.
- R5: Each sck half period lasts 2^div_sel system clocks, and a byte has exactly 16 sck edges. The done_flag becomes 1 on the (17 × 2^div_sel)-th rising clock edge after the edge that accepted the write, and not earlier.
- R6: The divider code is captured when a write is accepted. Changing div_sel during a byte has no effect on that byte's timing.
- R7: done_flag is set at the end of a byte. It is cleared by clr_done or by the next accepted write. irq equals irq_en AND done_flag.
- R8: A write while busy=1 sets wcol_flag on the next edge. It leaves the byte in flight unchanged. wcol_flag stays set until clr_wcol.
- R9: While master_mode=1 and en=1, a falling edge on ss_n_in sets fault_flag by the third rising edge after the fall. On that same edge, master_mode goes to 0, busy goes to 0, ss_n_out goes to 1 and sck returns to idle.
- R10: fault_flag stays set until clr_fault. While it is set, writes start nothing and mstr_set is ignored. After the flag is cleared, mstr_set restores master mode.
- R11: With en=0, the next edge ends any byte in flight and clears done_flag and wcol_flag. master_mode is not changed.
- R12: A write while master_mode=0 starts no transfer: busy stays 0 and ss_n_out stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Engine enable; 0 returns the engine and its flags to idle |
| mstr_set | input | 1 | One-cycle pulse that requests master mode |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: sample on first edge; 1: change on first edge, sample on second |
| div_sel | input | DIV_W | Divider code; half period is 2^div_sel clocks |
| irq_en | input | 1 | Interrupt enable for completion |
| wr_stb | input | 1 | Write strobe for the transmit byte |
| wr_data | input | DATA_W | Byte to send |
| clr_done | input | 1 | Clears done_flag |
| clr_wcol | input | 1 | Clears wcol_flag |
| clr_fault | input | 1 | Clears fault_flag |
| ss_n_in | input | 1 | Own select input, watched for bus takeover |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock, driven from a register |
| mosi | output | 1 | Serial data to the slave, driven from a register |
| ss_n_out | output | 1 | Slave select, active low, driven from a register |
| busy | output | 1 | A byte is in progress |
| master_mode | output | 1 | Block currently holds master mode |
| rx_data | output | DATA_W | Last byte received |
| done_flag | output | 1 | Byte complete |
| wcol_flag | output | 1 | Write collided with a byte in flight |
| fault_flag | output | 1 | Mode fault seen |
| irq | output | 1 | Completion interrupt |

## Verification
Every input is driven on a falling clock edge, and every output is read on the falling edge after the rising edge that should have changed it. Completion is checked twice: done_flag must still be 0 one edge before the 17 × 2^div_sel-th rising edge after the write is accepted, and must be 1 just after that edge. A fault must not show after the second rising edge that follows the fall of ss_n_in, and must show after the third, because the input passes two synchronizer stages and an edge detector. The collision flag, the enable abort and the flag clears are each read one edge after their stimulus. A slave model in the bench reacts to sck edges in the chosen mode. It supplies the expected rx_data and records what arrived on mosi.

// File: rtl/spi_mstr_pkg.sv
package spi_mstr_pkg;

   // How the divider code maps onto the SCK half period.
   typedef enum logic [0:0] {
      DIV_POW2   = 1'b0,   // half period = 2^code clocks
      DIV_LINEAR = 1'b1    // half period = code + 1 clocks
   } div_kind_e;

   // Width needed to hold the largest half period for a given code width.
   function automatic int half_width(input int code_w, input div_kind_e kind);
      if (kind == DIV_POW2) return (1 << code_w);
      else                  return code_w + 1;
   endfunction

endpackage

// File: rtl/spi_fall_sync.sv
// Brings an asynchronous active-low line into the clock domain and flags
// each falling edge of it for one cycle.
module spi_fall_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic fell
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_fall_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign fell = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/spi_clk_div.sv
// Produces one tick per SCK half period. The half period is captured at the
// start of each byte, so later changes to the code have no effect on it.
module spi_clk_div
   import spi_mstr_pkg::*;
#(
   parameter int        DIV_W    = 3,
   parameter div_kind_e DIV_KIND = DIV_POW2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [DIV_W-1:0] div_sel,
   output logic             tick
);

   localparam int HALF_W = half_width(DIV_W, DIV_KIND);

   logic [HALF_W-1:0] half_val;
   logic [HALF_W-1:0] half_q;
   logic [HALF_W-1:0] cnt_q;

   if (DIV_KIND == DIV_POW2) begin : g_pow2
      assign half_val = HALF_W'(1) << div_sel;
   end else begin : g_linear
      assign half_val = HALF_W'(div_sel) + HALF_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= HALF_W'(1);
         cnt_q  <= '0;
      end else if (load) begin
         half_q <= half_val;
         cnt_q  <= '0;
      end else if (run) begin
         if (cnt_q == half_q - HALF_W'(1)) cnt_q <= '0;
         else                              cnt_q <= cnt_q + HALF_W'(1);
      end else begin
         cnt_q <= '0;
      end
   end

   assign tick = run & (cnt_q == half_q - HALF_W'(1));

endmodule

// File: rtl/spi_shift_unit.sv
// Serial engine: edge counter, shift register, sample latch and the
// registered SCK, MOSI and select outputs for all four clock modes.
module spi_shift_unit #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              tick,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              miso,
   output logic              busy,
   output logic              sck,
   output logic              mosi,
   output logic              ss_n,
   output logic              finish,
   output logic [DATA_W-1:0] rx_final
);

   localparam int LAST   = 2 * DATA_W;
   localparam int EDGE_W = $clog2(LAST + 1);

   logic              busy_q;
   logic [EDGE_W-1:0] edge_q;
   logic [DATA_W-1:0] shreg_q;
   logic              smp_q;
   logic              mosi_q;
   logic              sck_q;
   logic              ss_q;
   logic              cpha_q;
   logic              at_end;
   logic              is_sample;

   assign at_end    = (edge_q == EDGE_W'(LAST));
   assign is_sample = (edge_q[0] == cpha_q);
   assign rx_final  = cpha_q ? {shreg_q[DATA_W-2:0], smp_q} : shreg_q;
   assign finish    = busy_q & tick & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         edge_q  <= '0;
         shreg_q <= '0;
         smp_q   <= 1'b0;
         mosi_q  <= 1'b0;
         sck_q   <= 1'b0;
         ss_q    <= 1'b1;
         cpha_q  <= 1'b0;
      end else if (abort) begin
         busy_q  <= 1'b0;
         edge_q  <= '0;
         shreg_q <= '0;
         smp_q   <= 1'b0;
         sck_q   <= cpol;
         ss_q    <= 1'b1;
      end else if (start) begin
         busy_q  <= 1'b1;
         edge_q  <= '0;
         shreg_q <= tx_data;
         smp_q   <= 1'b0;
         cpha_q  <= cpha;
         sck_q   <= cpol;
         ss_q    <= 1'b0;
         if (!cpha) mosi_q <= tx_data[DATA_W-1];
      end else if (busy_q && tick) begin
         if (at_end) begin
            busy_q  <= 1'b0;
            ss_q    <= 1'b1;
            edge_q  <= '0;
            shreg_q <= rx_final;
         end else begin
            sck_q  <= ~sck_q;
            edge_q <= edge_q + EDGE_W'(1);
            if (is_sample) begin
               smp_q <= miso;
            end else if (cpha_q && edge_q == '0) begin
               mosi_q <= shreg_q[DATA_W-1];
            end else begin
               shreg_q <= {shreg_q[DATA_W-2:0], smp_q};
               mosi_q  <= shreg_q[DATA_W-2];
            end
         end
      end else if (!busy_q) begin
         sck_q <= cpol;
      end
   end

   assign busy = busy_q;
   assign sck  = sck_q;
   assign mosi = mosi_q;
   assign ss_n = ss_q;

endmodule

// File: rtl/spi_mstr_core.sv
// Byte-wide serial master with a collision flag and mode-fault detection.
module spi_mstr_core
   import spi_mstr_pkg::*;
#(
   parameter int        DATA_W      = 8,
   parameter int        DIV_W       = 3,
   parameter div_kind_e DIV_KIND    = DIV_POW2,
   parameter int        SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              mstr_set,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [DIV_W-1:0]  div_sel,
   input  logic              irq_en,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr_done,
   input  logic              clr_wcol,
   input  logic              clr_fault,
   input  logic              ss_n_in,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              ss_n_out,
   output logic              busy,
   output logic              master_mode,
   output logic [DATA_W-1:0] rx_data,
   output logic              done_flag,
   output logic              wcol_flag,
   output logic              fault_flag,
   output logic              irq
);

   if (DATA_W < 2 || DATA_W > 64) begin : g_bad_data_w
      $error("spi_mstr_core: DATA_W out of range 2..64");
   end
   if (DIV_W < 1 || DIV_W > 5) begin : g_bad_div_w
      $error("spi_mstr_core: DIV_W out of range 1..5");
   end

   logic              tick;
   logic              fell;
   logic              finish;
   logic              start;
   logic              abort;
   logic              fault_evt;
   logic              busy_i;
   logic [DATA_W-1:0] rx_final;

   logic              master_q;
   logic              fault_q;
   logic              done_q;
   logic              wcol_q;
   logic [DATA_W-1:0] rx_q;

   assign fault_evt = en & master_q & fell;
   assign abort     = ~en | fault_evt;
   assign start     = wr_stb & en & master_q & ~fault_q & ~busy_i & ~fault_evt;

   spi_fall_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sel_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ss_n_in),
      .fell     (fell)
   );

   spi_clk_div #(
      .DIV_W    (DIV_W),
      .DIV_KIND (DIV_KIND)
   ) i_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start),
      .run     (busy_i),
      .div_sel (div_sel),
      .tick    (tick)
   );

   spi_shift_unit #(
      .DATA_W (DATA_W)
   ) i_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .abort    (abort),
      .tick     (tick),
      .cpol     (cpol),
      .cpha     (cpha),
      .tx_data  (wr_data),
      .miso     (miso),
      .busy     (busy_i),
      .sck      (sck),
      .mosi     (mosi),
      .ss_n     (ss_n_out),
      .finish   (finish),
      .rx_final (rx_final)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_q <= 1'b0;
         fault_q  <= 1'b0;
         done_q   <= 1'b0;
         wcol_q   <= 1'b0;
         rx_q     <= '0;
      end else begin
         if (fault_evt)                 master_q <= 1'b0;
         else if (mstr_set && !fault_q) master_q <= 1'b1;

         if (fault_evt)      fault_q <= 1'b1;
         else if (clr_fault) fault_q <= 1'b0;

         if (!en)                     done_q <= 1'b0;
         else if (finish)             done_q <= 1'b1;
         else if (start || clr_done)  done_q <= 1'b0;

         if (!en)                     wcol_q <= 1'b0;
         else if (wr_stb && busy_i)   wcol_q <= 1'b1;
         else if (clr_wcol)           wcol_q <= 1'b0;

         if (finish) rx_q <= rx_final;
      end
   end

   assign busy        = busy_i;
   assign master_mode = master_q;
   assign fault_flag  = fault_q;
   assign done_flag   = done_q;
   assign wcol_flag   = wcol_q;
   assign rx_data     = rx_q;
   assign irq         = irq_en & done_q;

endmodule

// File: rtl/spi_mstr_core_chk.sv
module spi_mstr_core_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic cpol,
   input logic wr_stb,
   input logic clr_wcol,
   input logic sck,
   input logic ss_n_out,
   input logic busy,
   input logic master_mode,
   input logic done_flag,
   input logic wcol_flag,
   input logic fault_flag
);

   assert_idle_sck_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !busy && !$past(busy) && $stable(cpol)) |-> (sck == cpol));

   assert_done_with_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> $rose(ss_n_out));

   assert_wcol_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wr_stb && busy && !clr_wcol) |=> wcol_flag);

   assert_fault_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_flag) |-> (!master_mode && ss_n_out && !busy));

   assert_fault_blocks_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_flag && !busy) |=> !busy);

   assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!busy && !done_flag && !wcol_flag));

   assert_slave_no_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_mode && !busy) |=> !busy);

endmodule

bind spi_mstr_core spi_mstr_core_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .cpol        (cpol),
   .wr_stb      (wr_stb),
   .clr_wcol    (clr_wcol),
   .sck         (sck),
   .ss_n_out    (ss_n_out),
   .busy        (busy),
   .master_mode (master_mode),
   .done_flag   (done_flag),
   .wcol_flag   (wcol_flag),
   .fault_flag  (fault_flag)
);

// File: tb/test_spi_mstr_core.sv
module test_spi_mstr_core;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       mstr_set = 1'b0;
   logic       cpol = 1'b0;
   logic       cpha = 1'b0;
   logic [2:0] div_sel = 3'd0;
   logic       irq_en = 1'b1;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       clr_done = 1'b0;
   logic       clr_wcol = 1'b0;
   logic       clr_fault = 1'b0;
   logic       ss_n_in = 1'b1;
   logic       miso = 1'b0;
   logic       sck, mosi, ss_n_out, busy, master_mode;
   logic [7:0] rx_data;
   logic       done_flag, wcol_flag, fault_flag, irq;

   int n_chk = 0;
   int n_err = 0;

   // slave model state
   logic [7:0] stx = 8'h00;
   logic [7:0] srx = 8'h00;
   int         sbit = 7;
   int         sck_edges = 0;
   logic       ss_prev = 1'b1;
   logic       sck_prev = 1'b0;
   logic       lead;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_mstr_core i_spi_mstr_core (
      .clk (clk), .rst_n (rst_n), .en (en), .mstr_set (mstr_set),
      .cpol (cpol), .cpha (cpha), .div_sel (div_sel), .irq_en (irq_en),
      .wr_stb (wr_stb), .wr_data (wr_data), .clr_done (clr_done),
      .clr_wcol (clr_wcol), .clr_fault (clr_fault), .ss_n_in (ss_n_in),
      .miso (miso), .sck (sck), .mosi (mosi), .ss_n_out (ss_n_out),
      .busy (busy), .master_mode (master_mode), .rx_data (rx_data),
      .done_flag (done_flag), .wcol_flag (wcol_flag),
      .fault_flag (fault_flag), .irq (irq)
   );

   // Behavioural slave: reacts to select and clock edges in the chosen mode.
   always @(ss_n_out or sck) begin
      if (ss_n_out !== ss_prev) begin
         ss_prev = ss_n_out;
         if (ss_n_out === 1'b0) begin
            srx = 8'h00;
            sck_edges = 0;
            sbit = 7;
            if (!cpha) begin
               miso = stx[7];
               sbit = 6;
            end
         end
      end
      if (sck !== sck_prev) begin
         sck_prev = sck;
         if (ss_n_out === 1'b0) begin
            sck_edges++;
            lead = (sck != cpol);
            if (lead != cpha) begin
               srx = {srx[6:0], mosi};
            end else if (sbit >= 0) begin
               miso = stx[sbit];
               sbit--;
            end
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic cycle();
      @(posedge clk);
      @(negedge clk);
   endtask

   // One byte exchange with timing, data and flag checks.
   task automatic run_xfer(input logic pol, input logic pha, input logic [2:0] dv,
                           input logic [7:0] md, input logic [7:0] sd, input bit collide);
      int half;
      half = 1 << dv;
      @(negedge clk);
      cpol = pol; cpha = pha; div_sel = dv; stx = sd; clr_done = 1'b1;
      cycle();
      clr_done = 1'b0; clr_wcol = 1'b1;
      cycle();
      clr_wcol = 1'b0;
      check("R7 done cleared by clr_done", {31'd0, done_flag}, 32'd0);
      check("R3 idle sck level", {31'd0, sck}, {31'd0, pol});
      wr_data = md; wr_stb = 1'b1;
      cycle();
      wr_stb = 1'b0;
      check("R2 select low after accept", {31'd0, ss_n_out}, 32'd0);
      for (int c = 1; c <= 17 * half; c++) begin
         if (c == 2) div_sel = dv ^ 3'd1;             // R6: mid-byte change
         if (collide && c == 3) begin
            wr_stb = 1'b1; wr_data = ~md;
         end else begin
            wr_stb = 1'b0;
         end
         cycle();
         if (c == 17 * half - 1)
            check("R5 done not early", {31'd0, done_flag}, 32'd0);
      end
      check("R5 R6 done on time", {31'd0, done_flag}, 32'd1);
      check("R2 rx byte", {24'd0, rx_data}, {24'd0, sd});
      check("R4 slave saw mosi byte", {24'd0, srx}, {24'd0, md});
      check("R5 sixteen sck edges", sck_edges, 32'd16);
      check("R3 sck back to idle", {31'd0, sck}, {31'd0, pol});
      check("R8 collision flag", {31'd0, wcol_flag}, {31'd0, collide});
      check("R7 irq follows done", {31'd0, irq}, 32'd1);
      div_sel = dv;
   endtask

   initial begin : watchdog
      repeat (WD_CYCLES) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      report();
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 select high", {31'd0, ss_n_out}, 32'd1);
      check("R1 busy", {31'd0, busy}, 32'd0);
      check("R1 master_mode", {31'd0, master_mode}, 32'd0);
      check("R1 flags", {29'd0, done_flag, wcol_flag, fault_flag}, 32'd0);
      check("R1 irq", {31'd0, irq}, 32'd0);

      // R12: write without master mode
      en = 1'b1; wr_data = 8'h5A; wr_stb = 1'b1;
      cycle();
      wr_stb = 1'b0;
      check("R12 no busy as slave", {31'd0, busy}, 32'd0);
      repeat (5) cycle();
      check("R12 select stays high", {31'd0, ss_n_out}, 32'd1);

      mstr_set = 1'b1;
      cycle();
      mstr_set = 1'b0;
      check("R10 master set", {31'd0, master_mode}, 32'd1);

      // Sweep of modes, divider codes and data
      for (int m = 0; m < 4; m++)
         for (int d = 0; d < 3; d++)
            for (int k = 0; k < 3; k++)
               run_xfer(m[1], m[0], d[2:0],
                        8'((m * 53 + d * 29 + k * 71 + 5) ^ 8'hA5),
                        8'((m * 17 + d * 97 + k * 41 + 3) ^ 8'h3C),
                        k == 1);

      // R7 clear by clr_done, irq drop
      clr_done = 1'b1;
      cycle();
      clr_done = 1'b0;
      check("R7 clr_done", {30'd0, done_flag, irq}, 32'd0);

      // R11: abort by en=0 with collision pending; start clears done
      run_xfer(1'b0, 1'b1, 3'd1, 8'hC3, 8'h96, 1'b0);
      wr_data = 8'h11; wr_stb = 1'b1;
      cycle();
      wr_stb = 1'b0;
      check("R7 done cleared by write", {31'd0, done_flag}, 32'd0);
      repeat (4) cycle();
      wr_stb = 1'b1;
      cycle();
      wr_stb = 1'b0;
      check("R8 wcol before abort", {31'd0, wcol_flag}, 32'd1);
      en = 1'b0;
      cycle();
      check("R11 busy cleared", {31'd0, busy}, 32'd0);
      check("R11 select high", {31'd0, ss_n_out}, 32'd1);
      check("R11 wcol cleared", {31'd0, wcol_flag}, 32'd0);
      check("R11 master kept", {31'd0, master_mode}, 32'd1);
      check("R11 sck idle", {31'd0, sck}, {31'd0, cpol});
      en = 1'b1;
      run_xfer(1'b1, 1'b1, 3'd0, 8'h3E, 8'hE7, 1'b0);

      // R9: mode fault during a byte
      cpol = 1'b1; cpha = 1'b0; div_sel = 3'd1;
      wr_data = 8'h77; wr_stb = 1'b1;
      cycle();
      wr_stb = 1'b0;
      repeat (8) cycle();
      ss_n_in = 1'b0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R9 fault not before third edge", {31'd0, fault_flag}, 32'd0);
      cycle();
      check("R9 fault set", {31'd0, fault_flag}, 32'd1);
      check("R9 master dropped", {31'd0, master_mode}, 32'd0);
      check("R9 busy dropped", {31'd0, busy}, 32'd0);
      check("R9 select released", {31'd0, ss_n_out}, 32'd1);
      check("R9 sck idle", {31'd0, sck}, 32'd1);
      ss_n_in = 1'b1;
      repeat (3) cycle();

      // R10: sticky fault blocks writes and mstr_set
      mstr_set = 1'b1;
      cycle();
      mstr_set = 1'b0;
      check("R10 mstr_set ignored", {31'd0, master_mode}, 32'd0);
      wr_stb = 1'b1;
      cycle();
      wr_stb = 1'b0;
      repeat (4) cycle();
      check("R10 no start under fault", {30'd0, busy, ~ss_n_out}, 32'd0);
      check("R10 fault sticky", {31'd0, fault_flag}, 32'd1);
      clr_fault = 1'b1;
      cycle();
      clr_fault = 1'b0;
      check("R10 fault cleared", {31'd0, fault_flag}, 32'd0);
      mstr_set = 1'b1;
      cycle();
      mstr_set = 1'b0;
      check("R10 master restored", {31'd0, master_mode}, 32'd1);
      run_xfer(1'b0, 1'b0, 3'd2, 8'h81, 8'h18, 1'b0);

      report();
   end

endmodule